// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Write Engine

This block is the write side of a two-wire serial EEPROM slave with 128 bytes of storage. It samples the clock and data lines through a short synchroniser and recognises start and stop conditions. It then takes in a control byte, a word address and a run of data bytes. Data bytes do not go straight into storage. They collect in an eight-byte page buffer, and the buffer is committed to the 128x8 register array only after the master ends the transaction cleanly. The commit happens during a timed internal write cycle.

The slave drives the data line only through an open-drain enable that pulls the line low. It does this in the acknowledge slot of each byte it accepts. During the internal write cycle a busy output is high and the slave acknowledges no control byte. Masters poll for completion in that way. A combinational inspection port gives the current content of any array location.

Top module: `i2c_eeprom_wr`

## Requirements
- R1: A start is seen when the synchronised data line falls while the synchronised clock line is high. A stop is seen when the data line rises while the clock line is high. A start always opens a new transaction.
- R2: A control byte whose bits [7:4] equal 1010 and whose bit 0 is 0 is acknowledged, for any value of bits [3:1]. The acknowledge holds `sda_pull_lo` high from shortly after the clock falls at the end of the eighth bit until shortly after the clock falls at the end of the ninth pulse.
- R3: A control byte with any other device code, or with bit 0 set to 1 (read), is not acknowledged. The slave then ignores the bus until the next start.
- R4: The byte after an accepted control byte is acknowledged and loads its bits [6:0] into the address pointer. Bit 7 of that byte is ignored.
- R5: Each following data byte is acknowledged and placed in the page-buffer slot given by pointer bits [2:0]. Those three bits then increment modulo 8, and pointer bits [6:3] stay fixed.
- R6: When more than eight data bytes arrive, the slot index wraps and later bytes overwrite earlier ones. No byte is ever written outside the page selected by pointer bits [6:3].
- R7: A stop at a byte boundary after at least one data byte raises `busy` for exactly WR_CYCLES clock cycles. The array stays unchanged until the end of that window. At the end, every buffered byte is written to its address in the page, and the page bytes not sent in the transaction keep their old values.
- R8: A stop that comes before any data byte starts no write cycle and changes no array content.
- R9: While `busy` is high, no control byte is acknowledged and the array is left as the pending commit sets it.
- R10: A start or stop that arrives after two or more clock rises of a byte aborts the transaction. The bytes buffered so far are discarded and no write cycle starts.
- R11: After reset `sda_pull_lo` and `busy` are low and every array byte is 0.
- R12: `peek_data` shows, without a clock delay, the array byte at `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw two-wire clock line |
| sda_in | input | 1 | Raw two-wire data line, as seen on the wire |
| sda_pull_lo | output | 1 | Open-drain enable; 1 pulls the data line low |
| busy | output | 1 | High during the internal write cycle |
| peek_addr | input | 7 | Array inspection address |
| peek_data | output | 8 | Array byte at `peek_addr` |

## Verification
The hardest case to reach is a control byte that arrives while a commit is still running. The write window must outlast a whole control byte on the bus. So the bench sets the cycle count well above one byte time and opens a new transaction at once after the stop that starts a commit. Aborted transactions are also hard to reach. They are built by bit-banging a partial byte and then issuing a stop or a repeated start mid-byte. The full array is compared after each one, which shows that the earlier buffered bytes were dropped while a later clean transaction still commits.

// File: rtl/eewr_pkg.sv
// Shared types and constants for the EEPROM slave write engine.
// Assumes: byte-wide data, MSB-first transfer on the two-wire bus.
package eewr_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_CTRL,
        LK_ADDR,
        LK_DATA
    } link_state_t;
endpackage

// File: rtl/eewr_sync.sv
// Line synchroniser and bus-condition detector.
// Samples SCL and SDA through STAGES flops each, then flags clock edges,
// start (SDA falls, SCL high) and stop (SDA rises, SCL high).
// Assumes: STAGES >= 2; the lines idle high.
module eewr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    assign scl_s   = scl_pipe[STAGES-1];
    assign sda_lvl = sda_pipe[STAGES-1];

    // Shift raw lines through the synchroniser and keep one prior sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_lvl;
        end
    end

    // Edge and condition decode on the synchronised lines (R1).
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_lvl;
        stop_det  = scl_s & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/eewr_link.sv
// Byte-level protocol engine for the write path.
// Counts SCL rises per byte, shifts data MSB first, decides the
// acknowledge after the eighth bit, and holds the address pointer whose
// low PAGE_W bits wrap inside the page.
// Assumes: ADDR_W <= BYTE_W; busy comes from the store.
module eewr_link
    import eewr_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sda_lvl,
    input  logic                     scl_rise,
    input  logic                     scl_fall,
    input  logic                     start_det,
    input  logic                     stop_det,
    input  logic                     busy,
    output logic                     ack_drv,
    output logic                     wr_stb,
    output logic [PAGE_W-1:0]        wr_idx,
    output logic [BYTE_W-1:0]        wr_data,
    output logic                     clr_stb,
    output logic                     commit_stb,
    output logic [ADDR_W-PAGE_W-1:0] commit_page
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    link_state_t         state;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [ADDR_W-1:0]   ptr;
    logic                got_data;
    logic                decide;
    logic                ctrl_ok;
    logic                at_boundary;

    // Strobes toward the store and per-byte decisions.
    always_comb begin
        at_boundary = (bit_cnt <= CNT_W'(1));
        decide      = scl_fall && (bit_cnt == LAST_BIT) && !ack_drv && (state != LK_IDLE);
        ctrl_ok     = (shreg[BYTE_W-1 -: 4] == DEV_CODE) && !shreg[0] && !busy;
        wr_stb      = decide && (state == LK_DATA);
        wr_idx      = ptr[PAGE_W-1:0];
        wr_data     = shreg;
        commit_stb  = stop_det && (state == LK_DATA) && at_boundary && got_data && !busy;
        clr_stb     = (start_det || stop_det) && !busy && !commit_stb;
        commit_page = ptr[ADDR_W-1:PAGE_W];
    end

    // Transaction state, bit counter, shifter, pointer and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LK_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            got_data <= 1'b0;
            ack_drv  <= 1'b0;
        end else if (start_det) begin
            state    <= LK_CTRL;
            bit_cnt  <= '0;
            got_data <= 1'b0;
            ack_drv  <= 1'b0;
        end else if (stop_det) begin
            state    <= LK_IDLE;
            bit_cnt  <= '0;
            got_data <= 1'b0;
            ack_drv  <= 1'b0;
        end else if (state != LK_IDLE) begin
            if (scl_rise) begin
                if (bit_cnt < LAST_BIT) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end else if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= ACK_BIT;
                end
            end else if (scl_fall) begin
                if (bit_cnt == ACK_BIT) begin
                    ack_drv <= 1'b0;
                    bit_cnt <= '0;
                end else if (decide) begin
                    case (state)
                        LK_CTRL: begin
                            if (ctrl_ok) begin
                                ack_drv <= 1'b1;
                                state   <= LK_ADDR;
                            end else begin
                                state   <= LK_IDLE;
                            end
                        end
                        LK_ADDR: begin
                            ptr     <= shreg[ADDR_W-1:0];
                            ack_drv <= 1'b1;
                            state   <= LK_DATA;
                        end
                        default: begin
                            ptr      <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                            ack_drv  <= 1'b1;
                            got_data <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // R2: the line is only pulled inside the acknowledge slot.
    p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drv |-> (bit_cnt == LAST_BIT || bit_cnt == ACK_BIT));

    // R9: a control byte decided during the write cycle gets no acknowledge.
    p_busy_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && state == LK_CTRL && busy) |=> !ack_drv);

    // R5: each stored byte advances only the in-page bits of the pointer.
    p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]) &&
                    ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + 1'b1));
endmodule

// File: rtl/eewr_store.sv
// Page buffer, per-slot valid flags, write-cycle timer and 2^ADDR_W x 8
// register array. Buffered bytes go to the array in the last cycle of
// the timed window; slots never written keep their array content.
// Assumes: no wr_stb or clr_stb arrives while busy (link gates them).
module eewr_store
    import eewr_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [PAGE_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic                     clr_stb,
    input  logic                     commit_stb,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic                     busy,
    output logic [BYTE_W-1:0]        rd_data
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int TAG_W      = ADDR_W - PAGE_W;
    localparam int TMR_W      = $clog2(WR_CYCLES + 1);

    logic [BYTE_W-1:0]     pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;
    logic [TAG_W-1:0]      page_q;
    logic [TMR_W-1:0]      tmr;
    logic [BYTE_W-1:0]     mem [DEPTH];
    logic                  mem_we;

    assign busy    = (tmr != '0);
    assign mem_we  = (tmr == TMR_W'(1));
    assign rd_data = mem[rd_addr];

    // Gather data bytes into their page slots; drop them on abort or commit end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
        end else if (mem_we || clr_stb) begin
            valid <= '0;
        end else if (wr_stb) begin
            pbuf[wr_idx]  <= wr_data;
            valid[wr_idx] <= 1'b1;
        end
    end

    // Time the internal write cycle and latch the target page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr    <= '0;
            page_q <= '0;
        end else if (commit_stb) begin
            tmr    <= TMR_W'(WR_CYCLES);
            page_q <= commit_page;
        end else if (busy) begin
            tmr    <= tmr - TMR_W'(1);
        end
    end

    // Commit every valid slot to the array at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (mem_we) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (valid[j]) mem[{page_q, PAGE_W'(j)}] <= pbuf[j];
            end
        end
    end

    // R9: a new commit is never requested while one is running.
    p_no_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit_stb);

    // R9: the pending buffer is frozen during the write cycle.
    p_flags_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(valid));

    // R7: once the write cycle ends nothing remains buffered.
    p_flags_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (valid == '0));
endmodule

// File: rtl/i2c_eeprom_wr.sv
// Top of the two-wire EEPROM slave write engine: synchroniser, protocol
// engine and page store. SDA is only ever pulled low, via sda_pull_lo.
// Assumes: sda_in is the wired value of the line, including this slave's pull.
module i2c_eeprom_wr
    import eewr_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int WR_CYCLES   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_lo,
    output logic              busy,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [BYTE_W-1:0] peek_data
);
    logic                     sda_lvl;
    logic                     scl_rise;
    logic                     scl_fall;
    logic                     start_det;
    logic                     stop_det;
    logic                     wr_stb;
    logic [PAGE_W-1:0]        wr_idx;
    logic [BYTE_W-1:0]        wr_data;
    logic                     clr_stb;
    logic                     commit_stb;
    logic [ADDR_W-PAGE_W-1:0] commit_page;

    eewr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eewr_link #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) link_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .busy        (busy),
        .ack_drv     (sda_pull_lo),
        .wr_stb      (wr_stb),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .clr_stb     (clr_stb),
        .commit_stb  (commit_stb),
        .commit_page (commit_page)
    );

    eewr_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .clr_stb     (clr_stb),
        .commit_stb  (commit_stb),
        .commit_page (commit_page),
        .rd_addr     (peek_addr),
        .busy        (busy),
        .rd_data     (peek_data)
    );
endmodule

// File: tb/i2c_eeprom_wr_tb_top.sv
// Bit-banging master bench with an arithmetic model of the array.
module i2c_eeprom_wr_tb_top;
    localparam int Q   = 8;
    localparam int WRC = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pull;
    logic       busy;
    logic [6:0] peek_addr = '0;
    logic [7:0] peek_data;
    wire        sda_bus = sda_m & ~pull;

    int         n_checks = 0;
    int         n_fail = 0;
    logic [7:0] model [128];
    logic [7:0] stg_d [8];
    bit         stg_v [8];
    logic [3:0] stg_pg;
    logic [6:0] stg_first;

    always #2 clk = ~clk;

    i2c_eeprom_wr #(.WR_CYCLES(WRC)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_bus),
        .sda_pull_lo (pull),
        .busy        (busy),
        .peek_addr   (peek_addr),
        .peek_data   (peek_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(input int seed, input int i);
        return 8'(seed * 29 + i * 53 + 7);
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            sda_m = b[7-i]; tick(Q);
            scl_m = 1'b1;   tick(2 * Q);
            scl_m = 1'b0;   tick(Q);
        end
    endtask

    task automatic get_ack(output bit a);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        a = !sda_bus;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic clear_stage(input logic [7:0] addr);
        for (int o = 0; o < 8; o++) stg_v[o] = 1'b0;
        stg_pg    = addr[6:3];
        stg_first = addr[6:0];
    endtask

    task automatic stage_byte(input logic [7:0] addr, input int i, input logic [7:0] d);
        int off;
        off = (int'(addr[2:0]) + i) % 8;
        stg_d[off] = d;
        stg_v[off] = 1'b1;
    endtask

    task automatic apply_stage();
        for (int o = 0; o < 8; o++)
            if (stg_v[o]) model[{stg_pg, 3'(o)}] = stg_d[o];
    endtask

    task automatic compare_mem(input string tag);
        for (int a = 0; a < 128; a++) begin
            peek_addr = 7'(a);
            #1;
            chk(peek_data == model[a], tag, peek_data, model[a]);
        end
    endtask

    // Wait for a write cycle, check the array is held, measure its length.
    task automatic wait_commit();
        int g;
        int cnt;
        g = 0;
        while (!busy && g < 40) begin tick(1); g++; end
        peek_addr = stg_first;
        #1;
        chk(peek_data == model[stg_first], "R7 array held during write cycle", peek_data, model[stg_first]);
        cnt = 0;
        while (busy && cnt < WRC + 10) begin cnt++; tick(1); end
        chk(cnt == WRC, "R7 busy length", cnt, WRC);
        apply_stage();
    endtask

    task automatic txn(input logic [7:0] ctrl, input logic [7:0] addr, input int n,
                       input int seed, input bit exp_ack);
        bit a;
        clear_stage(addr);
        bus_start();
        send_bits(ctrl, 8);
        get_ack(a);
        chk(a == exp_ack, "R1/R2/R3 control acknowledge", a, exp_ack);
        if (!a) begin
            bus_stop(); tick(20);
            chk(busy == 1'b0, "R3 no write after refused control", busy, 0);
            compare_mem("R3 array unchanged");
            return;
        end
        send_bits(addr, 8);
        get_ack(a);
        chk(a, "R4 address acknowledge", a, 1);
        for (int i = 0; i < n; i++) begin
            send_bits(dat(seed, i), 8);
            get_ack(a);
            chk(a, "R5 data acknowledge", a, 1);
            stage_byte(addr, i, dat(seed, i));
        end
        bus_stop();
        if (n == 0) begin
            tick(20);
            chk(busy == 1'b0, "R8 no write cycle without data", busy, 0);
        end else begin
            wait_commit();
        end
        tick(Q);
        compare_mem("R5/R6/R7 array contents");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit a;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R11: idle outputs and cleared array after reset (R12 peek path).
        chk(pull == 1'b0, "R11 pull released after reset", pull, 0);
        chk(busy == 1'b0, "R11 busy low after reset", busy, 0);
        compare_mem("R11/R12 array zero after reset");

        // R2, R7: single-byte writes, every block-select value.
        for (int b = 0; b < 8; b++)
            txn({4'b1010, 3'(b), 1'b0}, 8'(b * 16 + b), 1, b + 1, 1'b1);

        // R4: address bit 7 ignored.
        txn(8'hA0, 8'h85, 1, 50, 1'b1);

        // R2, R3, R8: every device code with both R/W values, address only.
        for (int c = 0; c < 32; c++) begin
            logic [7:0] cb;
            cb = {4'(c >> 1), 3'b011, 1'(c)};
            txn(cb, 8'h10, 0, 0, (cb[7:4] == 4'b1010) && !cb[0]);
        end

        // R5, R6: full page from mid-page offset wraps inside the page.
        txn(8'hA0, 8'h1B, 8, 60, 1'b1);
        // R6: eleven bytes overwrite the first three slots written.
        txn(8'hA4, 8'h42, 11, 61, 1'b1);
        // R7: partial page leaves unsent slots alone.
        txn(8'hA0, 8'h78, 8, 70, 1'b1);
        txn(8'hA2, 8'h7E, 3, 80, 1'b1);

        // R9: control byte during the write cycle is refused.
        clear_stage(8'h30);
        bus_start();
        send_bits(8'hA0, 8); get_ack(a);
        send_bits(8'h30, 8); get_ack(a);
        for (int i = 0; i < 2; i++) begin
            send_bits(dat(90, i), 8); get_ack(a);
            stage_byte(8'h30, i, dat(90, i));
        end
        bus_stop();
        tick(12);
        chk(busy == 1'b1, "R7 busy after stop", busy, 1);
        bus_start();
        send_bits(8'hA0, 8); get_ack(a);
        chk(a == 1'b0, "R9 control refused while busy", a, 0);
        bus_stop();
        tick(12);
        chk(busy == 1'b1, "R9 write cycle still running", busy, 1);
        while (busy) tick(1);
        apply_stage();
        tick(Q);
        compare_mem("R9 array after overlapped attempt");

        // R10: stop after three bits of a data byte aborts.
        bus_start();
        send_bits(8'hA0, 8); get_ack(a);
        send_bits(8'h50, 8); get_ack(a);
        send_bits(8'h11, 8); get_ack(a);
        send_bits(8'h22, 8); get_ack(a);
        send_bits(8'hFF, 3);
        bus_stop();
        tick(20);
        chk(busy == 1'b0, "R10 stop mid-byte starts no write", busy, 0);
        compare_mem("R10 array unchanged after mid-byte stop");

        // R10: repeated start mid-byte discards buffered bytes.
        bus_start();
        send_bits(8'hA0, 8); get_ack(a);
        send_bits(8'h60, 8); get_ack(a);
        send_bits(8'h33, 8); get_ack(a);
        send_bits(8'h44, 8); get_ack(a);
        send_bits(8'hFF, 5);
        clear_stage(8'h65);
        bus_start();
        send_bits(8'hA0, 8); get_ack(a);
        chk(a == 1'b1, "R1 repeated start opens transaction", a, 1);
        send_bits(8'h65, 8); get_ack(a);
        send_bits(8'h5A, 8); get_ack(a);
        stage_byte(8'h65, 0, 8'h5A);
        bus_stop();
        wait_commit();
        tick(Q);
        compare_mem("R10 only post-restart byte committed");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule